// File: doc/BRIEF.md
# CAN Interrupt Flag Controller

This block sits beside a CAN protocol engine and turns its event signals into latched interrupt flags. It handles three transmit buffers, a parameterized set of receive buffers or a receive FIFO, a message-error event, bus-activity wake-up while asleep, and an error summary event. A two-bit mode input picks how the flags are organized. In mode 0 every transmit and receive buffer owns a flag. In modes 1 and 2 the buffers feed one shared transmit flag and one shared receive flag, each buffer gated by its own enable bit. Mode 2 also watches the FIFO fill level against a programmable watermark.

The host reaches the block through a small register port: an address, a write strobe and write data, with read data returned combinationally. The host clears a flag by writing 0 to its bit. Writing 1 leaves the bit as it was. A flag whose cause is present in the same cycle as the clear stays set. One interrupt output is the OR of every flag ANDed with its enable. A separate wake output follows the wake flag.

Top module: `can_irq_flags`

## Requirements
- R1: After a synchronous active-high reset, all flags, enables, buffer gates and the watermark read 0, and `irq` and `wake` are 0.
- R2: In mode 0, a pulse on `tx_empty[i]` sets flag register 0 bit i in the next cycle (i = 0..2). Bit 3 (shared transmit) is never set in mode 0.
- R3: In modes 1 and 2, a pulse on `tx_empty[i]` with gate register (address 4) bit i set sets flag register 0 bit 3. Bits 0..2 are not set in these modes.
- R4: A pulse on `rx_loaded[i]` in mode 0 sets flag register 1 bit i. In modes 1 and 2 it sets flag register 0 bit 4 only when gate bit 4+i is set, and flag register 1 bits 0..NRX-1 are not set.
- R5: In mode 2 only, with a nonzero watermark (address 5), `fifo_level` at or above the watermark sets flag register 0 bit 5. A watermark of 0 disables the flag.
- R6: A `msg_err` pulse sets flag register 0 bit 6. An `err_evt` pulse sets flag register 1 bit 7.
- R7: `sleep` and `bus_act` high together set flag register 0 bit 7, and `wake` equals that bit. `bus_act` without `sleep` has no effect.
- R8: Writing to address 0 or 1 clears each flag whose data bit is 0 and leaves the flags whose data bit is 1. If the cause of a flag is present in the same cycle, the flag stays set.
- R9: `irq` is high exactly when some flag is set together with its enable bit: address 2 enables flag register 0 bit-for-bit, and address 3 enables flag register 1.
- R10: Addresses 2 to 5 are written and read back whole. Unused bits read 0: flag register 1 bits NRX..6, gate bits above 4+NRX-1 and bit 3, and watermark bits above LVL_W-1. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 per-buffer, 1 shared, 2 shared with FIFO watermark |
| tx_empty | input | 3 | Pulse per transmit buffer that became empty |
| rx_loaded | input | NRX | Pulse per receive buffer loaded after end of frame |
| fifo_level | input | LVL_W | Current receive FIFO fill level |
| msg_err | input | 1 | Message error event |
| err_evt | input | 1 | Error summary event (overflow or error state change) |
| sleep | input | 1 | Controller is in sleep |
| bus_act | input | 1 | Activity detected on the bus |
| wr | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Combined interrupt |
| wake | output | 1 | Wake-up request |

## Verification
The bench targets a host clear that lands in the same cycle as the flag's cause. A design that gives the clear priority would lose that event and leave the flag at 0. It switches modes while events keep arriving, which catches a per-buffer flag that still sets in a shared mode, or a shared flag that ignores a buffer's gate bit. It tests the watermark at exactly the fill level, one below it, and at 0, and outside mode 2. An off-by-one compare, or a watermark that still fires when disabled, shows up there. Bus activity without sleep checks that `wake` cannot set on its own.

// File: rtl/can_irq_flags.sv
module can_irq_flags #(
  parameter int NRX   = 4,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [2:0]       tx_empty,
  input  logic [NRX-1:0]   rx_loaded,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             msg_err,
  input  logic             err_evt,
  input  logic             sleep,
  input  logic             bus_act,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             irq,
  output logic             wake
);
  localparam logic [7:0] RXMASK = 8'((1 << NRX) - 1);
  localparam logic [7:0] FB_MASK = 8'h80 | RXMASK;
  localparam logic [7:0] GATE_MASK = 8'h07 | 8'(RXMASK << 4);

  logic [7:0] fa, fb, ena, enb, gate;
  logic [LVL_W-1:0] wm;
  logic [7:0] set_a, set_b, clr_a, clr_b;

  wire shared  = mode != 2'd0;
  wire fifo_md = mode == 2'd2;

  assign set_a[2:0] = shared ? 3'b000 : tx_empty;
  assign set_a[3]   = shared & |(tx_empty & gate[2:0]);
  assign set_a[4]   = shared & |(rx_loaded & gate[4 +: NRX]);
  assign set_a[5]   = fifo_md && (wm != '0) && (fifo_level >= wm);
  assign set_a[6]   = msg_err;
  assign set_a[7]   = sleep & bus_act;

  assign set_b = (shared ? 8'h00 : 8'(rx_loaded)) | {err_evt, 7'b0};

  assign clr_a = (wr && addr == 3'd0) ? ~wdata : 8'h00;
  assign clr_b = (wr && addr == 3'd1) ? ~wdata : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      fa   <= '0;
      fb   <= '0;
      ena  <= '0;
      enb  <= '0;
      gate <= '0;
      wm   <= '0;
    end else begin
      fa <= set_a | (fa & ~clr_a);
      fb <= (set_b | (fb & ~clr_b)) & FB_MASK;
      if (wr) begin
        case (addr)
          3'd2: ena  <= wdata;
          3'd3: enb  <= wdata & FB_MASK;
          3'd4: gate <= wdata & GATE_MASK;
          3'd5: wm   <= wdata[LVL_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = fa;
      3'd1:    rdata = fb;
      3'd2:    rdata = ena;
      3'd3:    rdata = enb;
      3'd4:    rdata = gate;
      3'd5:    rdata = 8'(wm);
      default: rdata = 8'h00;
    endcase
  end

  assign irq  = |(fa & ena) | |(fb & enb);
  assign wake = fa[7];
endmodule

module can_irq_flags_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic [2:0] tx_empty,
  input logic       msg_err,
  input logic       sleep,
  input logic       wr,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] fa,
  input logic [7:0] fb,
  input logic       irq
);
  // R2
  per_buf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && tx_empty[0]) |=> fa[0]);
  // R2
  no_shared_in_mode0_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && !fa[3]) |=> !fa[3]);
  // R3
  no_per_buf_in_shared_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd0 && fa[2:0] == 3'b000) |=> fa[2:0] == 3'b000);
  // R7
  wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !fa[7]) |=> !fa[7]);
  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 3'd0 && !wdata[6] && !msg_err) |=> !fa[6]);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    msg_err |=> fa[6]);
  // R9
  quiet_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (fa == 8'h00 && fb == 8'h00) |-> !irq);
endmodule

bind can_irq_flags can_irq_flags_chk u_chk (
  .clk(clk), .rst(rst), .mode(mode), .tx_empty(tx_empty), .msg_err(msg_err),
  .sleep(sleep), .wr(wr), .addr(addr), .wdata(wdata), .fa(fa), .fb(fb), .irq(irq)
);

// File: tb/sim_can_irq_flags.sv
module sim_can_irq_flags;
  localparam int NRX = 4;
  localparam int LVL_W = 5;
  localparam logic [7:0] FBM = 8'h80 | 8'((1 << NRX) - 1);
  localparam logic [7:0] GM = 8'h07 | 8'(8'((1 << NRX) - 1) << 4);

  logic clk = 0, rst = 1;
  logic [1:0] mode = 0;
  logic [2:0] tx_empty = 0;
  logic [NRX-1:0] rx_loaded = 0;
  logic [LVL_W-1:0] fifo_level = 0;
  logic msg_err = 0, err_evt = 0, sleep = 0, bus_act = 0, wr = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq, wake;

  int total = 0, bad = 0;
  logic [7:0] ma, mb, mea, meb, mg;
  logic [LVL_W-1:0] mw;

  always #5 clk = ~clk;

  can_irq_flags #(.NRX(NRX), .LVL_W(LVL_W)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .tx_empty(tx_empty), .rx_loaded(rx_loaded),
    .fifo_level(fifo_level), .msg_err(msg_err), .err_evt(err_evt), .sleep(sleep),
    .bus_act(bus_act), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq(irq), .wake(wake));

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return ma;
      3'd1: return mb;
      3'd2: return mea;
      3'd3: return meb;
      3'd4: return mg;
      3'd5: return 8'(mw);
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare();
    chk((addr < 2) ? "R2/R3/R4/R5/R6/R7/R8" : "R10", rdata, exp_rd(addr));
    chk("R9", {7'b0, irq}, {7'b0, |(ma & mea) | |(mb & meb)});
    chk("R7", {7'b0, wake}, {7'b0, ma[7]});
  endtask

  // inputs are stable at the negedge; the model computes the next state from them
  task automatic step();
    logic [7:0] sa, sb, ca, cb;
    logic sh;
    sh = mode != 0;
    sa[2:0] = sh ? 3'b0 : tx_empty;
    sa[3] = sh && ((tx_empty & mg[2:0]) != 0);
    sa[4] = sh && ((rx_loaded & mg[7:4]) != 0);
    sa[5] = (mode == 2) && (mw != 0) && (fifo_level >= mw);
    sa[6] = msg_err;
    sa[7] = sleep && bus_act;
    sb = (sh ? 8'h00 : 8'(rx_loaded)) | {err_evt, 7'b0};
    ca = (wr && addr == 0) ? ~wdata : 8'h00;
    cb = (wr && addr == 1) ? ~wdata : 8'h00;
    @(posedge clk);
    if (rst) begin
      ma = 0; mb = 0; mea = 0; meb = 0; mg = 0; mw = 0;
    end else begin
      ma = sa | (ma & ~ca);
      mb = (sb | (mb & ~cb)) & FBM;
      if (wr && addr == 2) mea = wdata;
      if (wr && addr == 3) meb = wdata & FBM;
      if (wr && addr == 4) mg = wdata & GM;
      if (wr && addr == 5) mw = wdata[LVL_W-1:0];
    end
    #1 compare();
    @(negedge clk);
  endtask

  task automatic quiet();
    tx_empty = 0; rx_loaded = 0; msg_err = 0; err_evt = 0;
    sleep = 0; bus_act = 0; wr = 0;
  endtask

  task automatic wreg(logic [2:0] a, logic [7:0] d);
    wr = 1; addr = a; wdata = d; step(); wr = 0;
  endtask

  task automatic rreg(logic [2:0] a);
    addr = a; step();
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog: got hung expected done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    step(); step();
    rst = 0;
    // R1 reset state of every register
    for (int a = 0; a < 8; a++) rreg(3'(a));

    // R2 mode 0 per-buffer transmit flags; R9 enables
    wreg(2, 8'hFF); wreg(3, FBM);
    mode = 0; tx_empty = 3'b101; step(); tx_empty = 0; rreg(0);
    // R8 clear while cause present keeps the flag, clear without cause drops it
    tx_empty = 3'b001; wreg(0, 8'h00); tx_empty = 0; rreg(0);
    wreg(0, 8'h00); rreg(0);
    // R3 shared transmit flag gated by buffer enables
    mode = 1; wreg(4, 8'h02); tx_empty = 3'b101; step(); tx_empty = 0; rreg(0);
    tx_empty = 3'b010; step(); tx_empty = 0; rreg(0);
    wreg(0, 8'h00);
    // R4 receive flags in both arrangements
    mode = 0; rx_loaded = 4'b0110; step(); rx_loaded = 0; rreg(1);
    mode = 2; wreg(4, 8'h10); rx_loaded = 4'b0010; step(); rx_loaded = 0; rreg(0);
    rx_loaded = 4'b0001; step(); rx_loaded = 0; rreg(0); rreg(1);
    wreg(0, 8'h00); wreg(1, 8'h00);
    // R5 watermark at, below, disabled and outside mode 2
    wreg(5, 8'd8); fifo_level = 7; step(); rreg(0);
    fifo_level = 8; step(); rreg(0);
    fifo_level = 7; wreg(0, 8'h00); rreg(0);
    fifo_level = 20; mode = 1; wreg(0, 8'h00); rreg(0);
    mode = 2; wreg(5, 8'd0); wreg(0, 8'h00); rreg(0);
    // R6 message error and error summary
    msg_err = 1; err_evt = 1; step(); quiet(); rreg(0); rreg(1);
    // R7 bus activity alone, then with sleep
    bus_act = 1; step(); rreg(0);
    sleep = 1; step(); quiet(); rreg(0);
    wreg(0, 8'h00); wreg(1, 8'h00);
    // R10 readback and masking of unused bits
    wreg(3, 8'hFF); wreg(4, 8'hFF); wreg(5, 8'hFF);
    for (int a = 2; a < 8; a++) rreg(3'(a));

    // randomized traffic against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 50 == 0) mode = 2'($urandom % 3);
      tx_empty   = ($urandom % 4 == 0) ? 3'($urandom) : 3'b0;
      rx_loaded  = ($urandom % 4 == 0) ? NRX'($urandom) : '0;
      fifo_level = LVL_W'($urandom);
      msg_err    = ($urandom % 8 == 0);
      err_evt    = ($urandom % 8 == 0);
      sleep      = ($urandom % 3 == 0);
      bus_act    = ($urandom % 3 == 0);
      wr         = ($urandom % 3 == 0);
      addr       = 3'($urandom);
      wdata      = 8'($urandom);
      step();
    end
    quiet();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule